// File: doc/BRIEF.md
# NAND Flash Command and Column-Pointer Front-End

This block is the control side of a small-page NAND memory device, seen from the memory bus. The host drives command, address and data bytes on a shared byte input. A rising edge of the write strobe latches the byte as a command when the command-latch pin is high, as an address byte when the address-latch pin is high, and as load data when both are low. Each falling edge of the read strobe returns one byte and advances the column. Both strobes are asynchronous to the block clock. They pass through a synchroniser and an edge detector before any decoding.

The storage cells are modelled by a 528-byte page RAM of two 256-byte halves and a 16-byte spare area. The time the cells would take is modelled by a busy counter with a separate duration parameter, in clock cycles, for each operation. A column pointer chooses where a read or a load begins. The pointer can be set to the low half, the high half or the spare area. A high-half setting is used for one operation only. The block also holds a status byte, answers an identification query and drives a ready flag (1 = ready).

The byte bus has no valid/ready handshake. Every byte is qualified by its own strobe edge. The host must not issue a strobe edge before the previous one has been decoded, which takes three clock cycles. The ready flag is the only flow control. While the flag is low, array reads, address bytes and data bytes are not acted on, and only the status and reset commands are taken.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset, rb is 1. Command 70h followed by one read strobe returns C0h when wp_n is 1.
- R2: The column a read or load starts at depends on the last pointer command and the first address byte b. Pointer command 00h gives b. Pointer command 01h gives 256+b. Pointer command 50h gives 512+b[3:0], and b[7:4] has no effect. Each read strobe then returns the byte at the column and moves the column up by one.
- R3: Using the high-half pointer (01h) for one read or one program moves the pointer back to the low half, so a following load without a pointer command starts at b. A spare-area pointer (50h) stays in place across programs.
- R4: Program runs as follows: 80h, three address bytes (column, then two row bytes), data bytes stored at consecutive columns, then 10h. This starts a busy period, and the status byte afterwards reads C0h.
- R5: A 10h that does not follow a complete load sequence starts nothing, and rb stays 1. A D0h that does not follow 60h and two address bytes also starts nothing.
- R6: While rb is 0, every command except 70h and FFh is ignored, and so are all address bytes. The output mode that was selected before is kept.
- R7: FFh starts a reset period of exactly T_RST cycles, even when the block is busy. It aborts the running operation, clears the fail bit and moves the pointer to the low half.
- R8: Status byte layout: bit 7 is wp_n, bit 6 is ready, bit 0 is fail (1 = failed), and bits 5..1 are 0. Reading status during a busy period with wp_n = 1 gives 80h.
- R9: Command 90h followed by address byte 00h makes the next two read strobes return ECh and then 75h.
- R10: The status byte stays selected for output until another command is accepted. While status is selected, read strobes do not move the column.
- R11: Erase runs as follows: 60h, two address bytes, then D0h. This holds rb at 0 for exactly T_ERASE cycles, and status then reads C0h.
- R12: rb is 0 for exactly T_PROG cycles after an accepted 10h and for exactly T_READ cycles after the third address byte of a read.
- R13: With wp_n = 0, a program or an erase still runs its busy period. Load data is not stored in the page RAM, and status then reads 41h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Device select, active low |
| cle | input | 1 | Byte on din is a command |
| ale | input | 1 | Byte on din is an address |
| we_n | input | 1 | Write strobe; the byte is latched on its rising edge |
| re_n | input | 1 | Read strobe; a byte is returned on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| din | input | 8 | Command, address or data byte |
| dout | output | 8 | Byte returned by the last read strobe |
| rb | output | 1 | Ready flag, 1 = ready |

## Verification
Directed sequences separate the three pointer areas. A high-half program followed by a load with no pointer command shows whether the pointer snaps back, and two spare loads in a row show whether the spare setting persists. Spare addresses with a nonzero upper nibble show whether those bits are masked. Commands sent during a busy period show the difference between ignoring and accepting them. The status byte and the ID query are sent during the busy period, and the reply that follows shows which output mode is selected. A protected program is followed by a read-back of the same column, which shows that stored data is untouched. Random programs into random areas, columns and lengths are read back against a byte-array model kept in the bench. Low-run lengths of rb are checked against each duration parameter.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {AREA_LO, AREA_HI, AREA_SPARE} area_t;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR_RD, PH_ADDR_PG, PH_LOAD, PH_ADDR_ER, PH_ER_CONF, PH_ADDR_ID
  } phase_t;
  typedef enum logic [1:0] {OM_ARRAY, OM_STATUS, OM_ID} omode_t;

  localparam logic [7:0] OP_PTR_LO   = 8'h00;
  localparam logic [7:0] OP_PTR_HI   = 8'h01;
  localparam logic [7:0] OP_PTR_SP   = 8'h50;
  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_PROG     = 8'h10;
  localparam logic [7:0] OP_ER_SETUP = 8'h60;
  localparam logic [7:0] OP_ER_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_RESET    = 8'hFF;
  localparam logic [7:0] ID_BYTE0    = 8'hEC;
  localparam logic [7:0] ID_BYTE1    = 8'h75;
endpackage

// File: rtl/nfc_strobe_sync.sv
module nfc_strobe_sync #(
  parameter int STAGES = 2,
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = sh[STAGES-1] & ~sh[STAGES];
    end else begin : g_fall
      assign pulse = ~sh[STAGES-1] & sh[STAGES];
    end
  endgenerate

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cycles,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= cycles;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_load_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cycles != '0) |=> busy);
  assert_count_down_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/nfc_page_ram.sv
module nfc_page_ram #(
  parameter int DEPTH = 528,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    assert_addr_range_R2: assert (!we || int'(addr) < DEPTH);
  end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nfc_pkg::*;
#(
  parameter int HALF    = 256,
  parameter int SPARE   = 16,
  parameter int T_READ  = 12,
  parameter int T_PROG  = 60,
  parameter int T_ERASE = 80,
  parameter int T_RST   = 6,
  parameter int TW      = 16,
  parameter int SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       rb
);
  localparam int PAGE = 2 * HALF + SPARE;
  localparam int CW   = $clog2(PAGE);
  localparam int SW   = $clog2(SPARE);
  localparam logic [CW-1:0] LAST_COL = CW'(PAGE - 1);

  logic we_rise, re_fall, busy;
  logic cmd_ev, adr_ev, dat_ev, rd_ev;
  logic tload, ram_we, fail, id_idx;
  logic [TW-1:0] tcyc;
  logic [CW-1:0] col;
  logic [1:0] acnt;
  logic [7:0] rdata, status;
  area_t  area;
  phase_t phase;
  omode_t omode;

  nfc_strobe_sync #(.STAGES(SYNC), .RISING(1'b1)) u_we (
    .clk(clk), .rst_n(rst_n), .pin(we_n), .pulse(we_rise));
  nfc_strobe_sync #(.STAGES(SYNC), .RISING(1'b0)) u_re (
    .clk(clk), .rst_n(rst_n), .pin(re_n), .pulse(re_fall));
  nfc_busy_timer #(.CW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .cycles(tcyc), .busy(busy));
  nfc_page_ram #(.DEPTH(PAGE)) u_ram (
    .clk(clk), .we(ram_we), .addr(col), .wdata(din), .rdata(rdata));

  assign cmd_ev = we_rise && !ce_n && cle && !ale;
  assign adr_ev = we_rise && !ce_n && ale && !cle;
  assign dat_ev = we_rise && !ce_n && !ale && !cle;
  assign rd_ev  = re_fall && !ce_n;
  assign status = {wp_n, ~busy, 5'b0, fail};
  assign rb     = ~busy;
  assign ram_we = dat_ev && !busy && phase == PH_LOAD && wp_n;

  function automatic logic [CW-1:0] start_col(area_t a, logic [7:0] b);
    case (a)
      AREA_HI:    return CW'(HALF) + CW'(b);
      AREA_SPARE: return CW'(2 * HALF) + CW'(b[SW-1:0]);
      default:    return CW'(b);
    endcase
  endfunction

  always_comb begin
    tload = 1'b0;
    tcyc  = '0;
    if (cmd_ev && din == OP_RESET) begin
      tload = 1'b1; tcyc = TW'(T_RST);
    end else if (cmd_ev && !busy && din == OP_PROG && phase == PH_LOAD) begin
      tload = 1'b1; tcyc = TW'(T_PROG);
    end else if (cmd_ev && !busy && din == OP_ER_GO && phase == PH_ER_CONF) begin
      tload = 1'b1; tcyc = TW'(T_ERASE);
    end else if (adr_ev && !busy && phase == PH_ADDR_RD && acnt == 2'd2) begin
      tload = 1'b1; tcyc = TW'(T_READ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area <= AREA_LO; phase <= PH_IDLE; omode <= OM_ARRAY;
      col <= '0; acnt <= '0; fail <= 1'b0; id_idx <= 1'b0; dout <= '0;
    end else if (cmd_ev) begin
      if (din == OP_RESET) begin
        area <= AREA_LO; phase <= PH_IDLE; omode <= OM_ARRAY; fail <= 1'b0;
      end else if (din == OP_STATUS) begin
        omode <= OM_STATUS;
      end else if (!busy) begin
        case (din)
          OP_PTR_LO: begin area <= AREA_LO; phase <= PH_ADDR_RD; acnt <= '0; omode <= OM_ARRAY; end
          OP_PTR_HI: begin area <= AREA_HI; phase <= PH_ADDR_RD; acnt <= '0; omode <= OM_ARRAY; end
          OP_PTR_SP: begin area <= AREA_SPARE; phase <= PH_ADDR_RD; acnt <= '0; omode <= OM_ARRAY; end
          OP_LOAD:     begin phase <= PH_ADDR_PG; acnt <= '0; end
          OP_ER_SETUP: begin phase <= PH_ADDR_ER; acnt <= '0; end
          OP_IDENT:    phase <= PH_ADDR_ID;
          OP_PROG, OP_ER_GO: begin
            if ((din == OP_PROG && phase == PH_LOAD) ||
                (din == OP_ER_GO && phase == PH_ER_CONF)) begin
              fail <= ~wp_n;
              if (area == AREA_HI) area <= AREA_LO;
            end
            phase <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end else if (adr_ev && !busy) begin
      case (phase)
        PH_ADDR_RD, PH_ADDR_PG: begin
          if (acnt == 2'd0) col <= start_col(area, din);
          acnt <= acnt + 2'd1;
          if (acnt == 2'd2) begin
            phase <= (phase == PH_ADDR_RD) ? PH_IDLE : PH_LOAD;
            if (phase == PH_ADDR_RD && area == AREA_HI) area <= AREA_LO;
          end
        end
        PH_ADDR_ER: begin
          acnt <= acnt + 2'd1;
          if (acnt == 2'd1) phase <= PH_ER_CONF;
        end
        PH_ADDR_ID: begin
          phase <= PH_IDLE;
          if (din == 8'h00) begin omode <= OM_ID; id_idx <= 1'b0; end
        end
        default: ;
      endcase
    end else if (dat_ev && !busy && phase == PH_LOAD) begin
      if (col != LAST_COL) col <= col + 1'b1;
    end else if (rd_ev) begin
      case (omode)
        OM_STATUS: dout <= status;
        OM_ID: begin dout <= id_idx ? ID_BYTE1 : ID_BYTE0; id_idx <= 1'b1; end
        default: if (!busy) begin
          dout <= rdata;
          if (col != LAST_COL) col <= col + 1'b1;
        end
      endcase
    end
  end

  assert_col_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) < PAGE);
  assert_prog_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !busy && din == OP_PROG && phase == PH_LOAD) |=> busy);
  assert_no_lone_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !busy && din == OP_PROG && phase != PH_LOAD) |=> !busy);
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_ev && din != OP_STATUS && din != OP_RESET)
      |=> ($stable(area) && $stable(phase) && $stable(omode)));
  assert_reset_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && din == OP_RESET) |=> (area == AREA_LO && !fail && busy));
  assert_status_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && omode == OM_STATUS) |=> $stable(col));
  assert_wp_no_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |-> !ram_we);
endmodule

// File: tb/nand_cmd_front_test.sv
`timescale 1ns/1ps
module nand_cmd_front_test;
  localparam int T_READ = 12, T_PROG = 60, T_ERASE = 80, T_RST = 6;

  logic clk = 0, rst_n = 0, ce_n = 0, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic rb;
  int nchk = 0, nfail = 0, run = 0, last_run = 0;
  logic [7:0] model [528];

  always #2 clk = ~clk;

  nand_cmd_front #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RST(T_RST)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .din(din), .dout(dout), .rb(rb));

  always @(negedge clk) begin
    if (!rb) run++;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk);
    cle = c; ale = a; din = v; we_n = 0;
    cyc(3); we_n = 1; cyc(4);
    cle = 0; ale = 0;
  endtask

  task automatic cmd(input logic [7:0] v); bus_wr(1, 0, v); endtask
  task automatic adr(input logic [7:0] v); bus_wr(0, 1, v); endtask
  task automatic dat(input logic [7:0] v); bus_wr(0, 0, v); endtask

  task automatic rd(output logic [7:0] v);
    re_n = 0; cyc(4); v = dout; re_n = 1; cyc(3);
  endtask

  task automatic wait_ready; cyc(3); while (!rb) cyc(1); cyc(2); endtask

  function automatic int base_of(input int area, input int b);
    if (area == 1) return 256 + b;
    if (area == 2) return 512 + (b % 16);
    return b;
  endfunction

  function automatic logic [7:0] ptr_op(input int area);
    return (area == 1) ? 8'h01 : (area == 2) ? 8'h50 : 8'h00;
  endfunction

  task automatic addr3(input logic [7:0] c); adr(c); adr(8'h12); adr(8'h00); endtask

  task automatic read_at(input int area, input logic [7:0] c);
    cmd(ptr_op(area)); addr3(c); wait_ready;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    cyc(3); rst_n = 1; cyc(3);

    chk("R1 rb after reset", rb, 1);
    cmd(8'h70); rd(v); chk("R1 status after reset", v, 8'hC0);

    cmd(8'h90); adr(8'h00);
    rd(v); chk("R9 id byte 0", v, 8'hEC);
    rd(v); chk("R9 id byte 1", v, 8'h75);

    // program low half at column 5
    cmd(8'h80); addr3(8'h05); dat(8'hAA); dat(8'hBB); cmd(8'h10); wait_ready;
    model[5] = 8'hAA; model[6] = 8'hBB;
    chk("R12 program busy length", last_run, T_PROG);
    cmd(8'h70); rd(v); chk("R4 status after program", v, 8'hC0);
    rd(v); chk("R10 status still selected", v, 8'hC0);
    read_at(0, 8'h05);
    chk("R12 read busy length", last_run, T_READ);
    rd(v); chk("R2 low half byte 0", v, 8'hAA);
    rd(v); chk("R2 low half byte 1", v, 8'hBB);

    // high-half pointer used once, then snaps back
    cmd(8'h01); cmd(8'h80); addr3(8'h10); dat(8'h11); cmd(8'h10); wait_ready;
    cmd(8'h80); addr3(8'h10); dat(8'h22); cmd(8'h10); wait_ready;
    model[272] = 8'h11; model[16] = 8'h22;
    read_at(1, 8'h10); rd(v); chk("R2 high half byte", v, 8'h11);
    read_at(0, 8'h10); rd(v); chk("R3 snap back to low half", v, 8'h22);

    // spare pointer persists, upper nibble ignored
    cmd(8'h50); cmd(8'h80); addr3(8'h23); dat(8'h33); cmd(8'h10); wait_ready;
    cmd(8'h80); addr3(8'h04); dat(8'h44); cmd(8'h10); wait_ready;
    model[515] = 8'h33; model[516] = 8'h44;
    read_at(2, 8'hF3);
    rd(v); chk("R2 spare offset masked", v, 8'h33);
    rd(v); chk("R3 spare pointer kept", v, 8'h44);

    // lone confirms
    cmd(8'h00); cmd(8'h10); chk("R5 lone 10h no busy", rb, 1); cyc(5);
    chk("R5 lone 10h still ready", rb, 1);
    cmd(8'hD0); cyc(2); chk("R5 lone D0h no busy", rb, 1);

    // commands during busy
    cmd(8'h80); addr3(8'h30); dat(8'h5A); cmd(8'h10);
    model[48] = 8'h5A;
    cmd(8'h70); rd(v); chk("R8 status while busy", v, 8'h80);
    cmd(8'h90); adr(8'h00);
    wait_ready; rd(v); chk("R6 id ignored while busy", v, 8'hC0);
    read_at(0, 8'h30); rd(v); chk("R4 data stored", v, 8'h5A);

    // reset during busy
    cmd(8'h50); cmd(8'h80); addr3(8'h01); dat(8'h66); cmd(8'h10);
    model[513] = 8'h66;
    cmd(8'hFF); wait_ready;
    cmd(8'h70); rd(v); chk("R7 status after abort", v, 8'hC0);
    cmd(8'h80); addr3(8'h02); dat(8'h55); cmd(8'h10); wait_ready;
    model[2] = 8'h55;
    read_at(0, 8'h02); rd(v); chk("R7 pointer back to low half", v, 8'h55);
    cmd(8'hFF); wait_ready; chk("R7 reset busy length", last_run, T_RST);

    // write protect
    wp_n = 0;
    cmd(8'h80); addr3(8'h05); dat(8'h99); cmd(8'h10); wait_ready;
    cmd(8'h70); rd(v); chk("R13 status protected program", v, 8'h41);
    wp_n = 1;
    read_at(0, 8'h05); rd(v); chk("R13 page unchanged", v, 8'hAA);

    // erase
    cmd(8'h60); adr(8'h20); adr(8'h01); cmd(8'hD0); wait_ready;
    chk("R11 erase busy length", last_run, T_ERASE);
    cmd(8'h70); rd(v); chk("R11 status after erase", v, 8'hC0);
    wp_n = 0;
    cmd(8'h60); adr(8'h20); adr(8'h01); cmd(8'hD0); wait_ready;
    cmd(8'h70); rd(v); chk("R13 status protected erase", v, 8'h41);
    wp_n = 1;

    // constrained random program and read-back
    for (int it = 0; it < 10; it++) begin
      int area, n, c, b;
      logic [7:0] cb;
      area = $urandom % 3;
      n = 1 + $urandom % 6;
      if (area == 2) begin
        c = $urandom % 10; cb = 8'(c) | 8'(($urandom % 16) << 4);
      end else begin
        c = $urandom % 250; cb = 8'(c);
      end
      b = base_of(area, int'(cb));
      cmd(ptr_op(area)); cmd(8'h80); addr3(cb);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        model[b + k] = d;
        dat(d);
      end
      cmd(8'h10); wait_ready;
      read_at(area, cb);
      for (int k = 0; k < n; k++) begin
        rd(v); chk("R2 R4 random read-back", v, model[b + k]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule